// File: doc/BRIEF.md
# NAND Read Prefetch Engine

This block pulls a programmed number of bytes from an 8-bit NAND data bus into a 64-byte internal FIFO, one byte per read strobe, while the host drains the FIFO as 32-bit words through a data port. Software sets up the engine through four registers: a run control, a configuration word, a byte count and a read-only status word. The status word shows how many bytes are still to be fetched and how many bytes sit in the FIFO, so the host knows how many whole words it can pop.

A run begins when software writes 1 to the control register. The byte count is copied into the remaining counter at that point. The engine then fetches whenever the NAND device reports ready, the FIFO has room and bytes are still owed. When every byte has been fetched and popped, the run flag clears by itself. Writing 0 to the control register ends a run early and empties the FIFO.

Two kinds of start request are turned away, and each raises a one-cycle error pulse: a start while a run is already in progress, and a start whose programmed threshold is above 64. The write-posting direction can be selected in the configuration word. Selecting it moves no data.

Top module: `nand_prefetch_engine`

## Requirements
- R1: After reset, the control, count and status registers read 0, and `nand_rd_strobe`, `thr_hit`, `err_busy` and `err_thresh` are 0.
- R2: Writing a word with bit 0 = 1 to the control register (address 0) while idle copies the count register (address 2, bits 13:0) into the remaining count. Each fetched byte lowers the remaining count by one. No byte is fetched while `nand_ready` is 0.
- R3: Bytes are fetched only while the FIFO holds fewer than 64 bytes and the remaining count is nonzero. FIFO occupancy never exceeds 64.
- R4: Data-port word layout and pop behaviour:
  - `dport_data` shows the oldest four FIFO bytes in little-endian order, with the first fetched byte in bits 7:0.
  - A pulse on `dport_rd` removes 4 bytes.
  - A pulse on `dport_rd` while fewer than 4 bytes are held leaves the occupancy unchanged.
- R5: The status register (address 3) holds the remaining count in bits 13:0 and the FIFO occupancy in bytes in bits 30:24. All other bits are 0.
- R6: Configuration register (address 1) layout and effect:
  - Fields: bit 0 is the direction (0 = read prefetch, 1 = write post), bit 7 is the enable, bits 15:8 are the threshold and bits 26:24 are the chip select.
  - Reading the register returns these fields as written.
  - `nand_cs` follows the chip-select field.
  - Bytes are fetched only when enable = 1 and direction = 0. A run started with direction = 1 or enable = 0 keeps its remaining count unchanged.
- R7: A start write while a run is in progress is refused. `err_busy` pulses for one cycle and the remaining count is unchanged.
- R8: A start write while the threshold field is above 64 is refused. `err_thresh` pulses for one cycle and the control register stays 0. A threshold of exactly 64 is accepted.
- R9: Writing 0 to the control register stops the run, clears the remaining count and empties the FIFO.
- R10: The control register clears by itself once a run has a remaining count of 0 and an empty FIFO.
- R11: `thr_hit` is 1 exactly when a run is in progress and the FIFO occupancy is at least the threshold field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 configuration, 2 count, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| dport_rd | input | 1 | Pop one word from the FIFO |
| dport_data | output | 32 | Oldest four FIFO bytes, little-endian |
| nand_ready | input | 1 | NAND device ready |
| nand_data | input | 8 | NAND read data, captured on the clock edge ending a strobe cycle |
| nand_rd_strobe | output | 1 | Byte read strobe towards the NAND device |
| nand_cs | output | 3 | Chip select taken from the configuration register |
| thr_hit | output | 1 | FIFO occupancy at or above the threshold during a run |
| err_busy | output | 1 | One-cycle pulse: start refused because a run is in progress |
| err_thresh | output | 1 | One-cycle pulse: start refused because the threshold is too large |

## Verification
The bound checker checks these on every cycle:
- a strobe is only issued with the device ready, the FIFO below 64 bytes and a nonzero remaining count;
- each strobe adds one byte to the FIFO and removes one from the remaining count;
- a pop with fewer than four bytes held leaves the occupancy alone;
- an idle, empty, fully counted run drops its run flag on the next edge;
- a threshold refusal never coincides with a run.

Only the directed scenarios can show the rest:
- the little-endian byte order of popped words and the field positions in the status and configuration words;
- the inactive write-post and disabled configurations;
- busy refusal and the exact 64-byte threshold boundary;
- the FIFO flush on stop.

// File: rtl/npf_pkg.sv
package npf_pkg;

    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = 14;
    localparam int CS_W       = 3;
    localparam int FIFO_BYTES = 64;
    localparam int THR_MAX    = 64;
    localparam int LVL_W      = $clog2(FIFO_BYTES) + 1;

    // field positions that software decodes
    localparam int CFG_DIR_BIT = 0;
    localparam int CFG_EN_BIT  = 7;
    localparam int CFG_THR_LO  = 8;
    localparam int CFG_CS_LO   = 24;
    localparam int ST_LVL_LO   = 24;

    typedef enum logic [1:0] {
        RA_CTRL   = 2'd0,
        RA_CFG    = 2'd1,
        RA_COUNT  = 2'd2,
        RA_STATUS = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [CS_W-1:0] cs;
        logic [7:0]      thr;
        logic            en;
        logic            dir_wr;
    } cfg_t;

    function automatic cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.cs     = w[CFG_CS_LO +: CS_W];
        c.thr    = w[CFG_THR_LO +: 8];
        c.en     = w[CFG_EN_BIT];
        c.dir_wr = w[CFG_DIR_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_pack(input cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CFG_CS_LO +: CS_W] = c.cs;
        w[CFG_THR_LO +: 8]   = c.thr;
        w[CFG_EN_BIT]        = c.en;
        w[CFG_DIR_BIT]       = c.dir_wr;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] status_pack(input logic [CNT_W-1:0] rem,
                                                      input logic [LVL_W-1:0] lvl);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CNT_W-1:0]           = rem;
        w[ST_LVL_LO +: LVL_W]  = lvl;
        return w;
    endfunction

endpackage

// File: rtl/npf_fifo.sv
module npf_fifo #(
    parameter  int DEPTH = 64,
    localparam int PW    = $clog2(DEPTH),
    localparam int LW    = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic          pop_req,
    output logic [31:0]   word_out,
    output logic [LW-1:0] level
);
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic          push_ok;
    logic          pop_ok;

    assign pop_ok  = pop_req && (level >= LW'(4));
    assign push_ok = push && (level < LW'(DEPTH));

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wp] <= push_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push_ok) begin
                wp <= wp + PW'(1);
            end
            if (pop_ok) begin
                rp <= rp + PW'(4);
            end
            level <= level + LW'(push_ok) - (pop_ok ? LW'(4) : LW'(0));
        end
    end

    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign word_out[8*k +: 8] = mem[rp + PW'(k)];
    end

endmodule

// File: rtl/npf_fetch.sv
module npf_fetch #(
    parameter int CNT_W = 14,
    parameter int DEPTH = 64,
    parameter int LW    = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             clear,
    input  logic [CNT_W-1:0] load_count,
    input  logic             active,
    input  logic             ready,
    input  logic [LW-1:0]    level,
    output logic             strobe,
    output logic [CNT_W-1:0] remaining
);
    assign strobe = active && (remaining != '0) && ready && (level < LW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_count;
        end else if (strobe) begin
            remaining <= remaining - CNT_W'(1);
        end
    end

endmodule

// File: rtl/npf_regs.sv
module npf_regs
    import npf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [CNT_W-1:0]  remaining,
    input  logic [LVL_W-1:0]  level,
    output cfg_t              cfg,
    output logic [CNT_W-1:0]  count_val,
    output logic              run,
    output logic              start,
    output logic              stop,
    output logic              err_busy,
    output logic              err_thresh
);
    logic ctrl_wr;
    logic go_req;
    logic thr_ok;
    logic done;

    assign ctrl_wr = wr && (reg_addr_e'(addr) == RA_CTRL);
    assign go_req  = ctrl_wr && wdata[0];
    assign thr_ok  = ({1'b0, cfg.thr} <= 9'(THR_MAX));
    assign start   = go_req && !run && thr_ok;
    assign stop    = ctrl_wr && !wdata[0];
    assign done    = run && (remaining == '0) && (level == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            run        <= 1'b0;
            cfg        <= '0;
            count_val  <= '0;
            err_busy   <= 1'b0;
            err_thresh <= 1'b0;
        end else begin
            err_busy   <= go_req && run;
            err_thresh <= go_req && !run && !thr_ok;
            if (stop) begin
                run <= 1'b0;
            end else if (start) begin
                run <= 1'b1;
            end else if (done) begin
                run <= 1'b0;
            end
            if (wr && (reg_addr_e'(addr) == RA_CFG)) begin
                cfg <= cfg_unpack(wdata);
            end
            if (wr && (reg_addr_e'(addr) == RA_COUNT)) begin
                count_val <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        unique case (reg_addr_e'(addr))
            RA_CTRL:   rdata = {{(WORD_W-1){1'b0}}, run};
            RA_CFG:    rdata = cfg_pack(cfg);
            RA_COUNT:  rdata = {{(WORD_W-CNT_W){1'b0}}, count_val};
            RA_STATUS: rdata = status_pack(remaining, level);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/nand_prefetch_engine.sv
module nand_prefetch_engine
    import npf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              dport_rd,
    output logic [WORD_W-1:0] dport_data,
    input  logic              nand_ready,
    input  logic [BYTE_W-1:0] nand_data,
    output logic              nand_rd_strobe,
    output logic [CS_W-1:0]   nand_cs,
    output logic              thr_hit,
    output logic              err_busy,
    output logic              err_thresh
);
    cfg_t             cfg;
    logic [CNT_W-1:0] count_val;
    logic [CNT_W-1:0] remaining;
    logic [LVL_W-1:0] fifo_level;
    logic             run;
    logic             start;
    logic             stop;
    logic             active;

    npf_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .remaining  (remaining),
        .level      (fifo_level),
        .cfg        (cfg),
        .count_val  (count_val),
        .run        (run),
        .start      (start),
        .stop       (stop),
        .err_busy   (err_busy),
        .err_thresh (err_thresh)
    );

    assign active = run && cfg.en && !cfg.dir_wr;

    npf_fetch #(.CNT_W(CNT_W), .DEPTH(FIFO_BYTES), .LW(LVL_W)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .load       (start),
        .clear      (stop),
        .load_count (count_val),
        .active     (active),
        .ready      (nand_ready),
        .level      (fifo_level),
        .strobe     (nand_rd_strobe),
        .remaining  (remaining)
    );

    npf_fifo #(.DEPTH(FIFO_BYTES)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (stop),
        .push      (nand_rd_strobe),
        .push_byte (nand_data),
        .pop_req   (dport_rd),
        .word_out  (dport_data),
        .level     (fifo_level)
    );

    assign nand_cs = cfg.cs;
    assign thr_hit = run && (16'(fifo_level) >= 16'(cfg.thr));

endmodule

// File: rtl/npf_checker.sv
module npf_checker #(
    parameter int DEPTH = 64,
    parameter int LW    = 7,
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             strobe,
    input logic             ready,
    input logic             dport_rd,
    input logic             run,
    input logic             err_thresh,
    input logic [LW-1:0]    level,
    input logic [CNT_W-1:0] remaining
);
    p_level_cap_r3: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    p_strobe_gate_r3: assert property (@(posedge clk) disable iff (rst)
        strobe |-> ready && (remaining != '0) && (level < LW'(DEPTH)));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (remaining == $past(remaining) - CNT_W'(1)) || (remaining == '0));

    p_push_grow_r3: assert property (@(posedge clk) disable iff (rst)
        strobe && !dport_rd |=> (level == $past(level) + LW'(1)) || (level == '0));

    p_short_pop_r4: assert property (@(posedge clk) disable iff (rst)
        dport_rd && (level < LW'(4)) && !strobe |=> (level == $past(level)) || (level == '0));

    p_auto_clear_r10: assert property (@(posedge clk) disable iff (rst)
        run && (remaining == '0) && (level == '0) |=> !run);

    p_thr_refused_r8: assert property (@(posedge clk) disable iff (rst)
        err_thresh |-> !run);

endmodule

bind nand_prefetch_engine npf_checker #(
    .DEPTH (npf_pkg::FIFO_BYTES),
    .LW    (npf_pkg::LVL_W),
    .CNT_W (npf_pkg::CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe     (nand_rd_strobe),
    .ready      (nand_ready),
    .dport_rd   (dport_rd),
    .run        (run),
    .err_thresh (err_thresh),
    .level      (fifo_level),
    .remaining  (remaining)
);

// File: tb/sim_nand_prefetch_engine.sv
`timescale 1ns/1ps
module sim_nand_prefetch_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dport_rd = 1'b0;
    logic [31:0] dport_data;
    logic        nand_ready = 1'b0;
    logic [7:0]  nand_data = '0;
    logic        nand_rd_strobe;
    logic [2:0]  nand_cs;
    logic        thr_hit;
    logic        err_busy;
    logic        err_thresh;

    int total = 0;
    int bad   = 0;
    int nand_idx = 0;
    bit finished = 0;

    localparam logic [1:0] A_CTRL = 2'd0, A_CFG = 2'd1, A_CNT = 2'd2, A_ST = 2'd3;

    always #10 clk = ~clk;

    nand_prefetch_engine u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dport_rd(dport_rd),
        .dport_data(dport_data), .nand_ready(nand_ready), .nand_data(nand_data),
        .nand_rd_strobe(nand_rd_strobe), .nand_cs(nand_cs), .thr_hit(thr_hit),
        .err_busy(err_busy), .err_thresh(err_thresh)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 53) & 255);
    endfunction

    // NAND model: present the next byte before the capturing edge
    always @(negedge clk) begin
        #2;
        if (nand_rd_strobe) begin
            nand_data = pat(nand_idx);
            nand_idx++;
        end
    end

    function automatic logic [31:0] cfgw(input int cs, input int thr, input bit en, input bit dir);
        return (32'(cs) << 24) | (32'(thr & 255) << 8) | (32'(en) << 7) | 32'(dir);
    endfunction

    function automatic logic [31:0] stw(input int lvl, input int rem);
        return (32'(lvl) << 24) | 32'(rem);
    endfunction

    function automatic logic [31:0] wexp(input int b);
        return {pat(b + 3), pat(b + 2), pat(b + 1), pat(b)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pop(output logic [31:0] d);
        d = dport_data;
        dport_rd = 1'b1;
        @(negedge clk);
        dport_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_CNT, v);  chk("R1 count", v, 0);
        rd(A_ST, v);   chk("R1 status", v, 0);
        chk("R1 outputs", {28'd0, nand_rd_strobe, thr_hit, err_busy, err_thresh}, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        int base;
        nand_ready = 1'b0;
        wr(A_CFG, cfgw(2, 8, 1, 0));
        wr(A_CNT, 12);
        wr(A_CTRL, 1);
        chk("R6 nand_cs", 32'(nand_cs), 2);
        rd(A_ST, v); chk("R2 loaded, no fetch without ready", v, stw(0, 12));
        idle(3);
        rd(A_ST, v); chk("R2 stall while not ready", v, stw(0, 12));
        base = nand_idx;
        nand_ready = 1'b1;
        idle(30);
        rd(A_ST, v); chk("R5 status fields after fetch", v, stw(12, 0));
        chk("R11 thr_hit at level 12 thr 8", 32'(thr_hit), 1);
        for (int k = 0; k < 3; k++) begin
            pop(v); chk("R4 little-endian word", v, wexp(base + 4 * k));
        end
        idle(1);
        rd(A_CTRL, v); chk("R10 auto clear", v, 0);
        rd(A_ST, v);   chk("R10 status empty", v, 0);
    endtask

    task automatic t_full();
        logic [31:0] v;
        int base;
        nand_ready = 1'b1;
        wr(A_CFG, cfgw(1, 64, 1, 0));
        wr(A_CNT, 100);
        base = nand_idx;
        wr(A_CTRL, 1);
        rd(A_CTRL, v); chk("R8 threshold 64 accepted", v, 1);
        idle(150);
        rd(A_ST, v); chk("R3 FIFO stops at 64", v, stw(64, 36));
        pop(v); chk("R4 first word", v, wexp(base));
        idle(10);
        rd(A_ST, v); chk("R3 refill after pop", v, stw(64, 32));
        pop(v); chk("R4 second word", v, wexp(base + 4));
        wr(A_CTRL, 0);
        rd(A_ST, v);   chk("R9 stop flushes", v, 0);
        rd(A_CTRL, v); chk("R9 stop clears run", v, 0);
        pop(v);
        rd(A_ST, v);   chk("R4 pop on empty ignored", v, 0);
        wr(A_CFG, cfgw(1, 8, 1, 0));
        wr(A_CNT, 2);
        wr(A_CTRL, 1);
        idle(10);
        rd(A_ST, v); chk("R4 two bytes held", v, stw(2, 0));
        pop(v);
        rd(A_ST, v); chk("R4 short pop ignored", v, stw(2, 0));
        wr(A_CTRL, 0);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        nand_ready = 1'b0;
        wr(A_CFG, cfgw(0, 8, 1, 0));
        wr(A_CNT, 8);
        wr(A_CTRL, 1);
        wr(A_CNT, 20);
        wr(A_CTRL, 1);
        chk("R7 busy pulse", 32'(err_busy), 1);
        rd(A_ST, v); chk("R7 remaining kept", v, stw(0, 8));
        idle(1);
        chk("R7 busy pulse ends", 32'(err_busy), 0);
        wr(A_CTRL, 0);
    endtask

    task automatic t_thresh();
        logic [31:0] v;
        nand_ready = 1'b1;
        wr(A_CFG, cfgw(0, 65, 1, 0));
        wr(A_CNT, 8);
        wr(A_CTRL, 1);
        chk("R8 thresh error pulse", 32'(err_thresh), 1);
        rd(A_CTRL, v); chk("R8 not started", v, 0);
        idle(5);
        rd(A_ST, v); chk("R8 nothing fetched", v, 0);
        chk("R8 thresh pulse ends", 32'(err_thresh), 0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        nand_ready = 1'b1;
        wr(A_CFG, cfgw(5, 32, 1, 1));
        rd(A_CFG, v); chk("R6 config readback", v, cfgw(5, 32, 1, 1));
        chk("R6 nand_cs 5", 32'(nand_cs), 5);
        wr(A_CNT, 8);
        wr(A_CTRL, 1);
        idle(10);
        rd(A_CTRL, v); chk("R6 write-post run accepted", v, 1);
        rd(A_ST, v);   chk("R6 write-post moves no data", v, stw(0, 8));
        wr(A_CTRL, 0);
        wr(A_CFG, cfgw(0, 8, 0, 0));
        wr(A_CTRL, 1);
        idle(10);
        rd(A_ST, v);   chk("R6 disabled moves no data", v, stw(0, 8));
        wr(A_CTRL, 0);
    endtask

    task automatic t_thrhit();
        logic [31:0] v;
        nand_ready = 1'b1;
        wr(A_CFG, cfgw(0, 8, 1, 0));
        wr(A_CNT, 4);
        wr(A_CTRL, 1);
        idle(10);
        rd(A_ST, v); chk("R11 level 4", v, stw(4, 0));
        chk("R11 below threshold", 32'(thr_hit), 0);
        wr(A_CFG, cfgw(0, 4, 1, 0));
        chk("R11 at threshold", 32'(thr_hit), 1);
        wr(A_CTRL, 0);
        chk("R11 idle no hit", 32'(thr_hit), 0);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_basic();
        t_full();
        t_busy();
        t_thresh();
        t_dir();
        t_thrhit();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule